// File: doc/BRIEF.md
# Word-to-Byte Bus Sizer

This bridge joins a 32-bit master port to a memory port that is only 8 bits wide. The master addresses whole words: its address is the byte address with the two byte-select bits removed, so it is two bits narrower than the slave address. Both sides still span the same number of bytes. The master says which parts of the word it wants with four byte enables.

Each master access becomes a series of single-byte slave accesses, one for each enabled byte lane. Lanes are taken in ascending order, and lanes whose enable is low are skipped. Lane numbering is little-endian: byte lane i is data bits [8i+7:8i] and sits at byte address {word address, i}. So the bytes 0,1,2,3 stored at consecutive addresses read back as 0x03020100.

The master is held with a wait signal until the last enabled lane is done. On a write the bridge hands each enabled byte to the slave. On a read it builds the word from the returned bytes.

Top module: `bus_sizer_w2b`

## Requirements
- R1: After reset, and whenever no request is pending, `m_wait`, `s_rd` and `s_wr` are low and `m_rdata` is zero.
- R2: Every slave access uses the byte address {request word address, lane index}. The lane index occupies slave address bits [1:0] and the word address occupies the bits above them.
- R3: Enabled lanes are visited in ascending order, from lane 0 to lane 3. A lane whose byte enable is low gets no slave access. Each enabled lane gets exactly one slave access.
- R4: A write to lane i drives `s_wdata` with master write data bits [8i+7:8i].
- R5: A read places the byte returned for lane i into `m_rdata` bits [8i+7:8i]. Disabled lanes read as zero. `m_rdata` is valid in the cycle in which `m_wait` is low and `m_req` is high.
- R6: `m_wait` is high from the cycle in which a request with at least one enable is accepted until the last enabled lane completes. No slave strobe occurs while `m_wait` is low.
- R7: A request with all four byte enables low completes in its first cycle. In that cycle `m_wait` is low and `m_rdata` is zero, and no slave access takes place.
- R8: `s_rd` and `s_wr` are never high together. Each byte write strobe lasts one cycle.
- R9: The slave has a one-cycle read latency. The byte is taken from `s_rdata` in the cycle after `s_rd`. No second read is issued in that cycle.
- R10: A write with k enabled lanes holds `m_wait` high for k+1 cycles. A read with k enabled lanes holds it high for 2k+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 1 | Master request, held until the cycle in which `m_wait` is low |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | M_AW | Master word address |
| m_be | input | DATA_W/SLV_W | Master byte enables, one per lane |
| m_wdata | input | DATA_W | Master write data |
| m_wait | output | 1 | Holds the master until the access is complete |
| m_rdata | output | DATA_W | Assembled read word |
| s_addr | output | M_AW+2 | Slave byte address |
| s_rd | output | 1 | Slave read strobe |
| s_wr | output | 1 | Slave write strobe |
| s_wdata | output | SLV_W | Slave write byte |
| s_rdata | input | SLV_W | Slave read byte, valid one cycle after `s_rd` |

## Verification
The assertions assume the master keeps `m_req`, `m_we`, `m_addr`, `m_be` and `m_wdata` stable from the cycle it raises the request until the cycle in which `m_wait` is low. They also assume the slave answers every read exactly one cycle later. Under those assumptions, checks on address, lane and write data compare slave traffic directly with the held master fields. The stimulus changes master inputs only half a cycle after the completing edge. A bench-side byte memory replies with the one-cycle latency and returns a marker byte in every other cycle, so a byte captured at the wrong moment shows up.

// File: rtl/sizer_pkg.sv
package sizer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_CAPT  = 2'd2,
      ST_DONE  = 2'd3
   } sz_state_e;
endpackage

// File: rtl/sz_lane_pick.sv
module sz_lane_pick #(
   parameter int LANES  = 4,
   parameter int LSEL_W = 2
) (
   input  logic [LANES-1:0]  mask_i,
   output logic [LSEL_W-1:0] lane_o
);
   // lowest pending lane wins: scan downwards so the last hit is the lowest
   always_comb begin
      lane_o = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (mask_i[i]) lane_o = LSEL_W'(i);
      end
   end
endmodule

// File: rtl/sz_ctrl.sv
module sz_ctrl
   import sizer_pkg::*;
#(
   parameter int M_AW   = 12,
   parameter int LANES  = 4,
   parameter int LSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic              m_we,
   input  logic [M_AW-1:0]   m_addr,
   input  logic [LANES-1:0]  m_be,
   input  logic [LSEL_W-1:0] lane_i,
   output logic [LANES-1:0]  pend_o,
   output logic [M_AW-1:0]   addr_o,
   output logic              load_o,
   output logic              capt_o,
   output logic              done_o,
   output logic              s_rd_o,
   output logic              s_wr_o,
   output logic              m_wait_o
);
   sz_state_e        state_q, state_n;
   logic [LANES-1:0] pend_q, pend_n, lane_bit, pend_left;
   logic             we_q;
   logic [M_AW-1:0]  addr_q;
   logic             any_be;

   assign any_be    = |m_be;
   assign lane_bit  = LANES'(1) << lane_i;
   assign pend_left = pend_q & ~lane_bit;

   always_comb begin
      state_n = state_q;
      pend_n  = pend_q;
      load_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (m_req && any_be) begin
               load_o  = 1'b1;
               pend_n  = m_be;
               state_n = ST_ISSUE;
            end
         end
         ST_ISSUE: begin
            if (we_q) begin
               pend_n  = pend_left;
               state_n = (|pend_left) ? ST_ISSUE : ST_DONE;
            end else begin
               state_n = ST_CAPT;
            end
         end
         ST_CAPT: begin
            pend_n  = pend_left;
            state_n = (|pend_left) ? ST_ISSUE : ST_DONE;
         end
         ST_DONE: state_n = ST_IDLE;
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         we_q    <= 1'b0;
         addr_q  <= '0;
      end else begin
         state_q <= state_n;
         pend_q  <= pend_n;
         if (load_o) begin
            we_q   <= m_we;
            addr_q <= m_addr;
         end
      end
   end

   assign pend_o   = pend_q;
   assign addr_o   = addr_q;
   assign capt_o   = (state_q == ST_CAPT);
   assign done_o   = (state_q == ST_DONE);
   assign s_rd_o   = (state_q == ST_ISSUE) && !we_q;
   assign s_wr_o   = (state_q == ST_ISSUE) && we_q;
   assign m_wait_o = (state_q == ST_IDLE) ? (m_req && any_be) : (state_q != ST_DONE);
endmodule

// File: rtl/sz_lane_pack.sv
module sz_lane_pack #(
   parameter int DATA_W = 32,
   parameter int SLV_W  = 8,
   parameter int LANES  = 4,
   parameter int LSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              capt_i,
   input  logic              done_i,
   input  logic [LSEL_W-1:0] lane_i,
   input  logic [DATA_W-1:0] m_wdata_i,
   input  logic [SLV_W-1:0]  s_rdata_i,
   output logic [SLV_W-1:0]  s_wdata_o,
   output logic [DATA_W-1:0] m_rdata_o
);
   logic [DATA_W-1:0] wdata_q;
   logic [SLV_W-1:0]  acc_q   [LANES];
   logic [SLV_W-1:0]  wslice  [LANES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
         for (int i = 0; i < LANES; i++) acc_q[i] <= '0;
      end else begin
         if (load_i) wdata_q <= m_wdata_i;
         for (int i = 0; i < LANES; i++) begin
            if (load_i) acc_q[i] <= '0;
            else if (capt_i && (lane_i == LSEL_W'(i))) acc_q[i] <= s_rdata_i;
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wslice[g] = wdata_q[g*SLV_W +: SLV_W];
      assign m_rdata_o[g*SLV_W +: SLV_W] = done_i ? acc_q[g] : '0;
   end

   assign s_wdata_o = wslice[lane_i];
endmodule

// File: rtl/bus_sizer_w2b.sv
module bus_sizer_w2b #(
   parameter int M_AW   = 12,
   parameter int DATA_W = 32,
   parameter int SLV_W  = 8,
   localparam int LANES  = DATA_W / SLV_W,
   localparam int LSEL_W = $clog2(LANES),
   localparam int S_AW   = M_AW + LSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic              m_we,
   input  logic [M_AW-1:0]   m_addr,
   input  logic [LANES-1:0]  m_be,
   input  logic [DATA_W-1:0] m_wdata,
   output logic              m_wait,
   output logic [DATA_W-1:0] m_rdata,
   output logic [S_AW-1:0]   s_addr,
   output logic              s_rd,
   output logic              s_wr,
   output logic [SLV_W-1:0]  s_wdata,
   input  logic [SLV_W-1:0]  s_rdata
);
   if (SLV_W * LANES != DATA_W) begin : g_bad_ratio
      $error("DATA_W must be a whole multiple of SLV_W");
   end
   if ((1 << LSEL_W) != LANES || LANES < 2) begin : g_bad_lanes
      $error("lane count must be a power of two of at least 2");
   end

   logic [LANES-1:0]  pend;
   logic [LSEL_W-1:0] lane;
   logic [M_AW-1:0]   addr_q;
   logic              load, capt, done;

   sz_lane_pick #(.LANES(LANES), .LSEL_W(LSEL_W)) pick_i (
      .mask_i (pend),
      .lane_o (lane)
   );

   sz_ctrl #(.M_AW(M_AW), .LANES(LANES), .LSEL_W(LSEL_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .m_req    (m_req),
      .m_we     (m_we),
      .m_addr   (m_addr),
      .m_be     (m_be),
      .lane_i   (lane),
      .pend_o   (pend),
      .addr_o   (addr_q),
      .load_o   (load),
      .capt_o   (capt),
      .done_o   (done),
      .s_rd_o   (s_rd),
      .s_wr_o   (s_wr),
      .m_wait_o (m_wait)
   );

   sz_lane_pack #(.DATA_W(DATA_W), .SLV_W(SLV_W), .LANES(LANES), .LSEL_W(LSEL_W)) pack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .capt_i    (capt),
      .done_i    (done),
      .lane_i    (lane),
      .m_wdata_i (m_wdata),
      .s_rdata_i (s_rdata),
      .s_wdata_o (s_wdata),
      .m_rdata_o (m_rdata)
   );

   assign s_addr = {addr_q, lane};
endmodule

// File: rtl/bus_sizer_w2b_chk.sv
module bus_sizer_w2b_chk #(
   parameter int M_AW   = 12,
   parameter int DATA_W = 32,
   parameter int SLV_W  = 8,
   localparam int LANES  = DATA_W / SLV_W,
   localparam int LSEL_W = $clog2(LANES),
   localparam int S_AW   = M_AW + LSEL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_req,
   input logic [M_AW-1:0]   m_addr,
   input logic [LANES-1:0]  m_be,
   input logic [DATA_W-1:0] m_wdata,
   input logic              m_wait,
   input logic [DATA_W-1:0] m_rdata,
   input logic [S_AW-1:0]   s_addr,
   input logic              s_rd,
   input logic              s_wr,
   input logic [SLV_W-1:0]  s_wdata
);
   logic              strobe;
   logic [LSEL_W-1:0] s_lane;
   logic              seen_q;
   logic [LSEL_W-1:0] last_q;

   assign strobe = s_rd || s_wr;
   assign s_lane = s_addr[LSEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (!m_wait) begin
         seen_q <= 1'b0;
      end else if (strobe) begin
         seen_q <= 1'b1;
         last_q <= s_lane;
      end
   end

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_req && !m_wait) |=> !strobe);
   p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (s_addr[S_AW-1:LSEL_W] == m_addr));
   p_lane_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> m_be[s_lane]);
   p_lane_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && seen_q) |-> (s_lane > last_q));
   p_wdata_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s_wr |-> (s_wdata == m_wdata[s_lane*SLV_W +: SLV_W]));
   p_strobe_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> m_wait);
   p_zero_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_be == '0) |-> (!m_wait && m_rdata == '0 && !strobe));
   p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_rd && s_wr));
   p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_wr |=> !(s_wr && $stable(s_addr)));
   p_rd_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      s_rd |=> !strobe);
endmodule

bind bus_sizer_w2b bus_sizer_w2b_chk #(.M_AW(M_AW), .DATA_W(DATA_W), .SLV_W(SLV_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .m_req   (m_req),
   .m_addr  (m_addr),
   .m_be    (m_be),
   .m_wdata (m_wdata),
   .m_wait  (m_wait),
   .m_rdata (m_rdata),
   .s_addr  (s_addr),
   .s_rd    (s_rd),
   .s_wr    (s_wr),
   .s_wdata (s_wdata)
);

// File: tb/bus_sizer_w2b_tb_top.sv
`timescale 1ns/1ps
module bus_sizer_w2b_tb_top;
   localparam int M_AW = 12;
   localparam int S_AW = M_AW + 2;

   typedef struct {
      bit         we;
      logic [S_AW-1:0] addr;
      logic [7:0] data;
   } acc_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            m_req = 1'b0;
   logic            m_we = 1'b0;
   logic [M_AW-1:0] m_addr = '0;
   logic [3:0]      m_be = '0;
   logic [31:0]     m_wdata = '0;
   logic            m_wait;
   logic [31:0]     m_rdata;
   logic [S_AW-1:0] s_addr;
   logic            s_rd, s_wr;
   logic [7:0]      s_wdata;
   logic [7:0]      s_rdata = 8'hA5;

   int   n_chk = 0;
   int   n_err = 0;
   int   cyc = 0;
   bit   finished = 1'b0;
   acc_t exp_q[$];
   logic [7:0] slave_mem [0:1023];
   logic [7:0] shadow    [0:1023];

   always #2.5 clk = ~clk;

   bus_sizer_w2b #(.M_AW(M_AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
      .m_be(m_be), .m_wdata(m_wdata), .m_wait(m_wait), .m_rdata(m_rdata),
      .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr), .s_wdata(s_wdata), .s_rdata(s_rdata)
   );

   // byte memory with one-cycle read latency; marker byte when no read answered
   always @(posedge clk) begin
      if (s_wr) slave_mem[s_addr[9:0]] <= s_wdata;
      s_rdata <= s_rd ? slave_mem[s_addr[9:0]] : 8'hA5;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every slave strobe must match the next queued expectation
   always begin
      @(negedge clk);
      #1;
      if (rst_n && (s_rd || s_wr)) begin
         if (exp_q.size() == 0) begin
            check("R3 unexpected slave access", {18'd0, s_addr}, 32'hFFFFFFFF);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            check("R8 strobe kind", {30'd0, s_rd, s_wr}, {30'd0, !e.we, e.we});
            check("R2 slave address", {18'd0, s_addr}, {18'd0, e.addr});
            if (e.we) check("R4 write byte", {24'd0, s_wdata}, {24'd0, e.data});
         end
      end
   end

   task automatic xfer(bit we, logic [M_AW-1:0] a, logic [3:0] be, logic [31:0] wd);
      int k = 0;
      int n = 0;
      logic [31:0] exp_rd = '0;
      for (int i = 0; i < 4; i++) begin
         if (be[i]) begin
            acc_t e;
            int idx;
            idx = a * 4 + i;
            k++;
            e.we = we;
            e.addr = {a, 2'(i)};
            e.data = wd[i*8 +: 8];
            exp_q.push_back(e);
            if (we) shadow[idx] = wd[i*8 +: 8];
            else exp_rd[i*8 +: 8] = shadow[idx];
         end
      end
      @(negedge clk);
      m_req = 1'b1; m_we = we; m_addr = a; m_be = be; m_wdata = wd;
      #1;
      while (m_wait && n < 100) begin
         n++;
         @(negedge clk);
         #1;
      end
      if (k == 0) check("R7 zero-enable wait cycles", n, 0);
      else check(we ? "R10 write wait cycles" : "R10 read wait cycles", n, we ? k + 1 : 2 * k + 1);
      if (!we) check(k == 0 ? "R7 zero-enable read data" : "R5 read word", m_rdata, exp_rd);
      @(negedge clk);
      m_req = 1'b0; m_be = '0;
      #1;
      check("R1 idle wait", {31'd0, m_wait}, 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         slave_mem[i] = 8'h00;
         shadow[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset wait", {31'd0, m_wait}, 32'd0);
      check("R1 reset strobes", {30'd0, s_rd, s_wr}, 32'd0);
      check("R1 reset rdata", m_rdata, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check("R1 idle strobes", {30'd0, s_rd, s_wr}, 32'd0);

      xfer(1'b1, 12'd0, 4'hF, 32'h03020100);
      xfer(1'b1, 12'd1, 4'hF, 32'h07060504);
      xfer(1'b0, 12'd0, 4'hF, 32'h0);
      check("R5 little-endian word 0", m_rdata, 32'h0); // idle again: output cleared
      xfer(1'b0, 12'd1, 4'hF, 32'h0);
      xfer(1'b1, 12'd2, 4'b0101, 32'hDDCCBBAA);   // R3 skip lanes 1 and 3
      xfer(1'b0, 12'd2, 4'hF, 32'h0);
      xfer(1'b0, 12'd1, 4'b1000, 32'h0);         // R9 single high lane
      xfer(1'b0, 12'd1, 4'b0110, 32'h0);
      xfer(1'b1, 12'd3, 4'b0000, 32'hFFFFFFFF);  // R7 no slave write
      xfer(1'b0, 12'd3, 4'hF, 32'h0);
      xfer(1'b0, 12'd1, 4'b0000, 32'h0);
      for (int b = 1; b < 16; b++) begin
         xfer(1'b1, 12'(8 + b), 4'(b), {8'(b), 8'(b + 16), 8'(b + 32), 8'(b + 48)});
      end
      for (int b = 1; b < 16; b++) begin
         xfer(1'b0, 12'(8 + b), 4'hF, 32'h0);
         xfer(1'b0, 12'(8 + b), 4'(b), 32'h0);
      end
      repeat (3) @(negedge clk);
      check("R3 all expected accesses seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL R6 watchdog actual=%0d cycles expected=completion", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
         end
      end
   end
endmodule